// File: doc/BRIEF.md
# Vector Integer Extension Unit

This unit carries out the vector zero-extend and sign-extend operations of a small vector core whose widest element is 32 bits. Each operation reads packed narrow elements from the low-order end of a 32-bit source word. The narrow width is the current element width (SEW) divided by the extension factor. Each narrow element is widened to SEW bits, either by filling the upper bits with zeros or by copying its top bit. The widened elements are then merged into the old destination word. The destination is never wider than SEW.

An operation is accepted on any cycle in which `in_valid` is high. The result and an illegal-operation flag appear one clock later and are qualified by `out_valid`. The elements that are written are limited by a vector length and a per-element mask. An operation whose factor does not fit the current SEW is flagged illegal and leaves the old destination word unchanged.

Top module: `vext_unit`

## Requirements
- R1: Result element i is SEW bits wide. It is built from source bits [(i+1)*SEW/f-1 : i*SEW/f], where f is the factor. For example, factor 2 with SEW 16 widens the bytes of `in_src[15:0]` into two 16-bit results. SEW is encoded on `in_sew` as 00=8, 01=16, 10=32.
- R2: When `in_sign`=0, the bits above the source element are filled with zeros.
- R3: When `in_sign`=1, the bits above the source element are filled with the source element's top bit.
- R4: Factor 2 (`in_factor`=01) is legal for SEW 16 and SEW 32 and illegal for SEW 8.
- R5: Factor 4 (`in_factor`=10) is legal only for SEW 32.
- R6: The following are always illegal: factor 8 (`in_factor`=11), the reserved factor code 00, and the reserved SEW code 11.
- R7: An illegal operation sets `out_illegal`=1 and returns `out_data` equal to `in_old`.
- R8: Result elements whose index is at or above `in_vl` keep their `in_old` value. A `in_vl` of 0 changes nothing.
- R9: A result element whose `in_mask` bit is 0 keeps its `in_old` value. `in_mask` bit i belongs to element i.
- R10: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. After reset, `out_valid`, `out_illegal` and `out_data` are 0.
- R11: `out_data` and `out_illegal` hold their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present |
| in_sign | input | 1 | 1 = sign-extend, 0 = zero-extend |
| in_factor | input | 2 | 01 = factor 2, 10 = factor 4, 11 = factor 8, 00 reserved |
| in_sew | input | 2 | 00 = 8, 01 = 16, 10 = 32, 11 reserved |
| in_vl | input | 3 | Number of active elements in the word |
| in_mask | input | 4 | Per-element write enable |
| in_src | input | 32 | Packed narrow source elements |
| in_old | input | 32 | Previous destination word |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Operation was illegal |
| out_data | output | 32 | Destination word |

## Verification
Every result (`out_valid`, `out_illegal` and `out_data`) is due on the first rising edge after the operation is presented. The bench drives each operation on a falling edge and compares outputs at the next falling edge, half a period after the result register loads. Hold behaviour is checked one more falling edge later, with `in_valid` low and different data on the inputs.

// File: rtl/vext_pkg.sv
package vext_pkg;
    localparam int WORD_W = 32;
    localparam int NBYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        SEW_8   = 2'b00,
        SEW_16  = 2'b01,
        SEW_32  = 2'b10,
        SEW_RSV = 2'b11
    } sew_e;

    typedef enum logic [1:0] {
        FAC_RSV = 2'b00,
        FAC_2   = 2'b01,
        FAC_4   = 2'b10,
        FAC_8   = 2'b11
    } fac_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [WORD_W-1:0] data;
    } res_t;
endpackage

// File: rtl/vext_legal.sv
module vext_legal
    import vext_pkg::*;
(
    input  logic [1:0] sew_i,
    input  logic [1:0] fac_i,
    output logic       legal_o
);
    always_comb begin
        unique case (fac_i)
            FAC_2:   legal_o = (sew_i == SEW_16) || (sew_i == SEW_32);
            FAC_4:   legal_o = (sew_i == SEW_32);
            default: legal_o = 1'b0;
        endcase
    end

    always_comb begin
        if (legal_o) begin
            AST_LEGAL_NEEDS_SEW_ROOM: assert (sew_i != SEW_8 && sew_i != SEW_RSV); // R4
        end
    end
endmodule

// File: rtl/vext_widen.sv
module vext_widen #(
    parameter int WORD_W = 32,
    parameter int SRC_W  = 8,
    parameter int DST_W  = 16,
    localparam int NELEM = WORD_W / DST_W,
    localparam int IN_W  = NELEM * SRC_W
) (
    input  logic              sign_i,
    input  logic [IN_W-1:0]   src_i,
    output logic [WORD_W-1:0] dst_o
);
    for (genvar g = 0; g < NELEM; g++) begin : g_elem
        logic fill;
        assign fill = sign_i & src_i[g*SRC_W + SRC_W - 1];
        assign dst_o[g*DST_W +: DST_W] = {{(DST_W - SRC_W){fill}}, src_i[g*SRC_W +: SRC_W]};
    end
endmodule

// File: rtl/vext_unit.sv
module vext_unit
    import vext_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sign,
    input  logic [1:0]  in_factor,
    input  logic [1:0]  in_sew,
    input  logic [2:0]  in_vl,
    input  logic [3:0]  in_mask,
    input  logic [31:0] in_src,
    input  logic [31:0] in_old,
    output logic        out_valid,
    output logic        out_illegal,
    output logic [31:0] out_data
);
    logic              legal;
    logic [WORD_W-1:0] w_h16, w_h32, w_q32, widened;
    logic [NBYTES-1:0] byte_en;
    res_t              s_d, s_q;

    vext_legal u_legal (.sew_i(in_sew), .fac_i(in_factor), .legal_o(legal));

    vext_widen #(.WORD_W(WORD_W), .SRC_W(8),  .DST_W(16)) u_h16 (
        .sign_i(in_sign), .src_i(in_src[15:0]), .dst_o(w_h16));
    vext_widen #(.WORD_W(WORD_W), .SRC_W(16), .DST_W(32)) u_h32 (
        .sign_i(in_sign), .src_i(in_src[15:0]), .dst_o(w_h32));
    vext_widen #(.WORD_W(WORD_W), .SRC_W(8),  .DST_W(32)) u_q32 (
        .sign_i(in_sign), .src_i(in_src[7:0]),  .dst_o(w_q32));

    always_comb begin
        if (in_sew == SEW_16)      widened = w_h16;
        else if (in_factor == FAC_4) widened = w_q32;
        else                        widened = w_h32;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [1:0] idx;
        always_comb begin
            unique case (in_sew)
                SEW_16:  idx = 2'(b / 2);
                SEW_32:  idx = 2'(b / 4);
                default: idx = 2'(b);
            endcase
        end
        assign byte_en[b] = ({1'b0, idx} < in_vl) && in_mask[idx];
    end

    always_comb begin
        s_d = s_q;
        if (in_valid) begin
            s_d.illegal = ~legal;
            s_d.data    = in_old;
            if (legal) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (byte_en[b]) s_d.data[b*8 +: 8] = widened[b*8 +: 8];
                end
            end
        end
        s_d.valid = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid   = s_q.valid;
    assign out_illegal = s_q.illegal;
    assign out_data    = s_q.data;

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_VF8_REJECTED: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_factor == FAC_8) |=> out_illegal); // R6
    AST_ILLEGAL_WRITES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_illegal) |-> out_data == $past(in_old)); // R7
    AST_ZERO_VL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_vl == 3'd0) |=> out_data == $past(in_old)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data) && $stable(out_illegal)); // R11
endmodule

// File: tb/sim_vext_unit.sv
module sim_vext_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sign = 1'b0;
    logic [1:0]  in_factor = 2'b00, in_sew = 2'b00;
    logic [2:0]  in_vl = 3'd0;
    logic [3:0]  in_mask = 4'h0;
    logic [31:0] in_src = '0, in_old = '0;
    logic        out_valid, out_illegal;
    logic [31:0] out_data;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    vext_unit u0 (.*);

    function automatic logic [32:0] model(input logic sg, input logic [1:0] f, input logic [1:0] sw,
                                          input logic [2:0] vl, input logic [3:0] m,
                                          input logic [31:0] src, input logic [31:0] old);
        int   ew, sw_b, n;
        logic ok;
        logic [63:0] res, e, smask, dmask;
        ok = (f == 2'b01 && (sw == 2'b01 || sw == 2'b10)) || (f == 2'b10 && sw == 2'b10);
        if (!ok) return {1'b1, old};
        ew   = 8 << sw;
        sw_b = (f == 2'b01) ? ew / 2 : ew / 4;
        n    = 32 / ew;
        res  = {32'h0, old};
        smask = (64'd1 << sw_b) - 1;
        dmask = (64'd1 << ew) - 1;
        for (int i = 0; i < n; i++) begin
            if (i < int'(vl) && m[i]) begin
                e = ({32'h0, src} >> (i * sw_b)) & smask;
                if (sg && e[sw_b-1]) e = e | (dmask & ~smask);
                res = (res & ~(dmask << (i * ew))) | (e << (i * ew));
            end
        end
        return {1'b0, res[31:0]};
    endfunction

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got illegal=%0b data=%08h, expected illegal=%0b data=%08h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic op(input string req, input logic sg, input logic [1:0] f, input logic [1:0] sw,
                      input logic [2:0] vl, input logic [3:0] m, input logic [31:0] src, input logic [31:0] old);
        in_valid = 1'b1; in_sign = sg; in_factor = f; in_sew = sw;
        in_vl = vl; in_mask = m; in_src = src; in_old = old;
        @(negedge clk);
        chk({req, " (R10 valid)"}, {32'h0, out_valid}, 33'd1);
        chk(req, {out_illegal, out_data}, model(sg, f, sw, vl, m, src, old));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [32:0] held;
        void'($urandom(32'd2024));
        @(negedge clk); @(negedge clk);
        chk("R10 reset", {out_illegal, out_data}, 33'd0);
        chk("R10 reset valid", {32'h0, out_valid}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corner cases
        op("R1 vf2 sew16 zext",  1'b0, 2'b01, 2'b01, 3'd2, 4'hF, 32'hDEAD_81F0, 32'h1111_1111);
        chk("R1 vf2 sew16 value", {out_illegal, out_data}, {1'b0, 32'h0081_00F0});
        op("R2 vf4 zext",        1'b0, 2'b10, 2'b10, 3'd1, 4'hF, 32'hFFFF_FF80, 32'h0);
        chk("R2 vf4 zero fill",  {out_illegal, out_data}, {1'b0, 32'h0000_0080});
        op("R3 vf4 sext",        1'b1, 2'b10, 2'b10, 3'd1, 4'hF, 32'h0000_0080, 32'h0);
        chk("R3 vf4 sign fill",  {out_illegal, out_data}, {1'b0, 32'hFFFF_FF80});
        op("R3 vf2 sew32 sext",  1'b1, 2'b01, 2'b10, 3'd1, 4'h1, 32'h0000_8001, 32'h0);
        op("R4 vf2 sew8",        1'b0, 2'b01, 2'b00, 3'd4, 4'hF, 32'h1234_5678, 32'hCAFE_F00D);
        op("R5 vf4 sew16",       1'b1, 2'b10, 2'b01, 3'd2, 4'hF, 32'h1234_5678, 32'hCAFE_F00D);
        op("R6 vf8 sew32",       1'b0, 2'b11, 2'b10, 3'd1, 4'hF, 32'h1234_5678, 32'hABCD_0123);
        op("R6 reserved factor", 1'b0, 2'b00, 2'b10, 3'd1, 4'hF, 32'h1234_5678, 32'h5555_AAAA);
        op("R6 reserved sew",    1'b0, 2'b01, 2'b11, 3'd1, 4'hF, 32'h1234_5678, 32'h0F0F_0F0F);
        chk("R7 illegal keeps old", {out_illegal, out_data}, {1'b1, 32'h0F0F_0F0F});
        op("R8 vl zero",         1'b1, 2'b01, 2'b01, 3'd0, 4'hF, 32'h0000_FFFF, 32'h7777_7777);
        op("R8 vl one",          1'b1, 2'b01, 2'b01, 3'd1, 4'hF, 32'h0000_FFFF, 32'h7777_7777);
        chk("R8 tail kept",      {out_illegal, out_data}, {1'b0, 32'h7777_FFFF});
        op("R9 mask elem0 off",  1'b0, 2'b01, 2'b01, 3'd2, 4'h2, 32'h0000_AB12, 32'h9999_9999);
        chk("R9 masked kept",    {out_illegal, out_data}, {1'b0, 32'h00AB_9999});
        // R11 hold with in_valid low
        held = {out_illegal, out_data};
        in_valid = 1'b0; in_src = 32'hFFFF_FFFF; in_old = 32'h0; in_factor = 2'b11;
        @(negedge clk);
        chk("R10 idle no valid", {32'h0, out_valid}, 33'd0);
        chk("R11 hold",          {out_illegal, out_data}, held);
        // constrained random
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] f, sw;
            f  = ($urandom % 8 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'b01 : 2'b10);
            sw = ($urandom % 8 == 0) ? 2'($urandom) : 2'(1 + $urandom % 2);
            op("R1 random", 1'($urandom), f, sw, 3'($urandom % 6), 4'($urandom),
               $urandom, $urandom);
        end
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule